// File: doc/BRIEF.md
# NRZI / MLT-3 Transmit Symbol Serializer

This block sits at the end of a 100 Mb/s transmit path. Each symbol period it takes one 5-bit code group from an upstream encoder or scrambler and sends it out one bit per clock, so the line rate is five times the symbol rate. The serial stream is then line-coded onto one of two outputs. A single-bit NRZI output toggles on every 1 bit. A two-bit MLT-3 level output steps through three levels on every 1 bit.

The block runs entirely on the fast bit clock. A one-cycle strobe `sym_stb`, raised on every fifth clock, marks each symbol boundary and stands in for the rising edge of the symbol-rate reference. On that cycle the block captures the group on `grp_data` if `grp_vld` is high. If `grp_vld` is low, it loads an idle group of all ones instead. The line-code selector is sampled on the same cycle, so one group is never split between two line codes. Reset is synchronous and active high.

Top module: `nrzi_mlt3_tx_ser`

## Requirements
- R1: While reset is high, and on the first clock after reset, `tx_nrzi` is 0 and `tx_mlt3` is 2'b00. After reset, the first MLT-3 step goes to +1.
- R2: `grp_vld`, `grp_data` and `sel_mlt3` are ignored on every cycle where `sym_stb` is low. Changing them in the middle of a group does not change the line output.
- R3: Each captured group is sent over five consecutive clocks, bit 0 first and bit 4 last.
- R4: In NRZI mode (`sel_mlt3`=0 at the boundary), a 1 bit inverts `tx_nrzi` and a 0 bit leaves it unchanged.
- R5: In MLT-3 mode (`sel_mlt3`=1 at the boundary), each 1 bit moves `tx_mlt3` one step through the repeating order 0, +1, 0, -1. The levels are encoded as 0 = 2'b00, +1 = 2'b01 and -1 = 2'b11. The code 2'b10 never appears.
- R6: In MLT-3 mode, a 0 bit leaves `tx_mlt3` unchanged.
- R7: If `grp_vld` is low at a boundary, the group sent is 5'b11111, not the previous group.
- R8: The mode is fixed for a whole group. While NRZI is active, `tx_mlt3` holds its level. While MLT-3 is active, `tx_nrzi` holds its value. Each line coder resumes from the state where it stopped.
- R9: Bit 0 of a group captured at a boundary edge is already visible on the outputs right after that same edge. Each later bit appears one clock after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (five times the symbol rate) |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | Symbol boundary strobe, high one cycle in five |
| grp_vld | input | 1 | A new code group is offered at this boundary |
| grp_data | input | GRP_W | Code group, bit 0 is sent first |
| sel_mlt3 | input | 1 | Line code for the next group: 0 NRZI, 1 MLT-3 |
| tx_nrzi | output | 1 | NRZI serial output |
| tx_mlt3 | output | 2 | MLT-3 level: 00 zero, 01 plus, 11 minus |

## Verification
Every output is registered, and every input is consumed on the edge at which it is presented. The effect of bit 0 is therefore due right after the boundary edge, and bit k is due k clocks later. The bench's driver computes the expected output pair for every clock edge from the requirements and queues it at the falling edge before that edge. The monitor pops one entry a moment after each rising edge, so each expected value is lined up with the edge that produces it. Noise on the inputs during mid-group cycles is checked by the same per-edge comparison, which shows that it never reaches the line.

// File: rtl/nrzi_mlt3_tx_ser.sv
module nrzi_mlt3_tx_ser #(
  parameter int GRP_W = 5,
  parameter logic [GRP_W-1:0] IDLE_GRP = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_stb,
  input  logic             grp_vld,
  input  logic [GRP_W-1:0] grp_data,
  input  logic             sel_mlt3,
  output logic             tx_nrzi,
  output logic [1:0]       tx_mlt3
);
  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_NEG  = 2'b11;

  logic [GRP_W-1:0] sh_q;
  logic             mode_q;
  logic             up_q;
  logic             nrzi_q;
  logic [1:0]       lvl_q;

  wire [GRP_W-1:0] grp_in   = grp_vld ? grp_data : IDLE_GRP;
  wire             cur_bit  = sym_stb ? grp_in[0] : sh_q[0];
  wire             cur_mode = sym_stb ? sel_mlt3 : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      mode_q <= 1'b0;
      up_q   <= 1'b1;
      nrzi_q <= 1'b0;
      lvl_q  <= LV_ZERO;
    end else begin
      if (sym_stb) begin
        sh_q   <= grp_in >> 1;
        mode_q <= sel_mlt3;
      end else begin
        sh_q   <= sh_q >> 1;
      end
      if (cur_bit && !cur_mode)
        nrzi_q <= ~nrzi_q;
      if (cur_bit && cur_mode) begin
        case (lvl_q)
          LV_ZERO: lvl_q <= up_q ? LV_POS : LV_NEG;
          LV_POS: begin
            lvl_q <= LV_ZERO;
            up_q  <= 1'b0;
          end
          default: begin
            lvl_q <= LV_ZERO;
            up_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  assign tx_nrzi = nrzi_q;
  assign tx_mlt3 = lvl_q;

  AST_MLT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    tx_mlt3 != 2'b10); // R5
  AST_MLT_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    (tx_mlt3 != $past(tx_mlt3)) |-> (tx_mlt3 == LV_ZERO || $past(tx_mlt3) == LV_ZERO)); // R5
  AST_NRZI_FROZEN: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> $stable(tx_nrzi)); // R8
  AST_MLT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> $stable(tx_mlt3)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (tx_nrzi == 1'b0 && tx_mlt3 == LV_ZERO)); // R1
endmodule

// File: tb/nrzi_mlt3_tx_ser_test.sv
module nrzi_mlt3_tx_ser_test;
  localparam int CLK_PERIOD = 8;
  localparam int WDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_stb = 1'b0;
  logic       grp_vld = 1'b0;
  logic [4:0] grp_data = '0;
  logic       sel_mlt3 = 1'b0;
  logic       tx_nrzi;
  logic [1:0] tx_mlt3;

  nrzi_mlt3_tx_ser uut (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .grp_vld(grp_vld),
    .grp_data(grp_data), .sel_mlt3(sel_mlt3), .tx_nrzi(tx_nrzi), .tx_mlt3(tx_mlt3)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit drv_done = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  logic [4:0] m_sh = '0;
  logic       m_mode = 1'b0;
  logic       m_n = 1'b0;
  logic [1:0] m_lvl = 2'b00;
  logic       m_up = 1'b1;

  task automatic model_edge(input string tag);
    logic b;
    logic md;
    logic [4:0] g;
    if (rst) begin
      m_sh = '0; m_mode = 1'b0; m_n = 1'b0; m_lvl = 2'b00; m_up = 1'b1;
    end else begin
      if (sym_stb) begin
        g = grp_vld ? grp_data : 5'b11111;
        b = g[0]; md = sel_mlt3; m_mode = sel_mlt3; m_sh = g >> 1;
      end else begin
        b = m_sh[0]; md = m_mode; m_sh = m_sh >> 1;
      end
      if (b && !md) m_n = ~m_n;
      if (b && md) begin
        if (m_lvl == 2'b00) m_lvl = m_up ? 2'b01 : 2'b11;
        else if (m_lvl == 2'b01) begin m_lvl = 2'b00; m_up = 1'b0; end
        else begin m_lvl = 2'b00; m_up = 1'b1; end
      end
    end
    exp_q.push_back({m_n, m_lvl});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst = 1'b1; sym_stb = 1'b0; grp_vld = 1'b0;
      model_edge("R1");
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  // noisy: mid-group cycles carry junk on the data, valid and mode inputs
  task automatic send_grp(input logic vld, input logic [4:0] d, input logic md,
                          input bit noisy, input string tag);
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      sym_stb = (i == 0);
      if (i == 0) begin
        grp_vld = vld; grp_data = d; sel_mlt3 = md;
      end else if (noisy) begin
        grp_vld = 1'b1; grp_data = ~d ^ 5'(i); sel_mlt3 = ~md;
      end else begin
        grp_vld = 1'b0; grp_data = '0; sel_mlt3 = md;
      end
      model_edge(i == 0 ? {tag, "/R9"} : tag);
    end
    @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if ({tx_nrzi, tx_mlt3} !== e) begin
        n_fail++;
        $display("FAIL %s: nrzi=%b mlt3=%b expected nrzi=%b mlt3=%b",
                 t, tx_nrzi, tx_mlt3, e[2], e[1:0]);
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset(3);
    send_grp(1'b1, 5'b10110, 1'b0, 1'b0, "R3");
    send_grp(1'b1, 5'b00001, 1'b0, 1'b0, "R3");
    send_grp(1'b1, 5'b00000, 1'b0, 1'b0, "R4");
    send_grp(1'b1, 5'b11111, 1'b0, 1'b0, "R4");
    send_grp(1'b0, 5'b00100, 1'b0, 1'b0, "R7");
    send_grp(1'b1, 5'b11111, 1'b1, 1'b0, "R5");
    send_grp(1'b1, 5'b01011, 1'b1, 1'b0, "R5");
    send_grp(1'b1, 5'b00000, 1'b1, 1'b0, "R6");
    send_grp(1'b1, 5'b10001, 1'b1, 1'b0, "R6");
    send_grp(1'b0, 5'b00010, 1'b1, 1'b0, "R7");
    send_grp(1'b1, 5'b00010, 1'b0, 1'b1, "R2");
    send_grp(1'b1, 5'b00000, 1'b1, 1'b1, "R2");
    send_grp(1'b1, 5'b11011, 1'b0, 1'b0, "R8");
    send_grp(1'b1, 5'b00111, 1'b1, 1'b0, "R8");
    send_grp(1'b1, 5'b10101, 1'b0, 1'b1, "R8");
    send_grp(1'b1, 5'b00110, 1'b1, 1'b1, "R8");
    do_reset(2);
    send_grp(1'b1, 5'b00001, 1'b1, 1'b0, "R1");
    send_grp(1'b1, 5'b00011, 1'b1, 1'b0, "R5");
    @(negedge clk);
    @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!(drv_done && exp_q.size() == 0) && cyc < WDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= WDOG_CYCLES) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer than %0d",
               cyc, WDOG_CYCLES);
    end
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule